// File: doc/BRIEF.md
# Entropy Sample Health Monitor

This block sits between a hardware noise source and a deterministic random bit generator. Every 8-bit raw sample passes through two statistical health tests: a run-length test that catches a stuck source, and a windowed proportion test that catches a source biased towards one value. After a startup phase of 1024 clean samples, accepted samples are packed into a 512-bit seed block. The generator takes the seed through a ready/request handshake.

Each completed seed block is compared with the block completed before it, so that a source repeating itself at block scale is also caught. Any failure latches an error flag and a specific error code. From then on no seed is released until the block is reset.

The cutoffs follow from an assumed min-entropy of 6.31 bits per sample. The run cutoff is derived from that figure as 1 + ceil(20 / H) = 5. The proportion window (512 samples) and its cutoff (13) are parameters.

Top module: `entropy_health_monitor`

## Requirements
- R1: During and after reset, seed_ready is 0, fail_flag is 0 and err_code is 0x00.
- R2: The first 1024 valid samples after reset are health-tested but not packed, and seed_ready stays 0 throughout that phase.
- R3: After startup, 64 consecutive packed samples form one seed. The k-th packed sample (k = 0..63) sits in seed_data bits [8k+7:8k], and seed_ready rises within two clock cycles after the 64th sample is taken.
- R4: While seed_ready is 1 and seed_req is 0, seed_data and seed_ready hold. Samples arriving in that time are tested but not packed. One cycle after a cycle with seed_req and seed_ready both 1, seed_ready is 0, and packing restarts at slot 0 with the next sample.
- R5: Five identical valid samples in a row (idle cycles between them do not break the run) set fail_flag with err_code 0x2C on the fifth; four in a row do not fail.
- R6: Proportion windows are 512 valid samples long, starting at the first sample after reset. When the number of samples in a window equal to its first sample (the first sample included) reaches 13, fail_flag is set with err_code 0x2D; 12 do not fail.
- R7: A completed seed block equal to the previously completed block sets fail_flag with err_code 0x1E, and that block is never offered.
- R8: Once set, fail_flag and err_code hold until reset, seed_ready stays 0 (a pending seed is withdrawn) and seed_req has no effect; reset clears them.
- R9: When one sample fails both the run test and the proportion test, err_code is 0x2C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Raw sample strobe |
| smp_data | input | 8 | Raw noise sample |
| seed_req | input | 1 | Generator takes the offered seed |
| seed_ready | output | 1 | A full seed block is offered |
| seed_data | output | 512 | Seed block, sample k at bits [8k+7:8k] |
| fail_flag | output | 1 | Sticky health failure |
| err_code | output | 8 | 0x2C run test, 0x2D proportion test, 0x1E repeated block, 0x00 none |

## Verification
The checker watches these properties on every cycle: the error flag and code are sticky and legal, no seed is offered while in error or before 1024 samples, an offered seed stays stable until it is taken, and a take withdraws the ready flag. Other behaviours can only be shown by the bench's scenarios: the byte packing order, the exact sample on which each test trips (four versus five repeats, twelve versus thirteen matches), the priority when two tests trip together, the discarding of samples while a seed waits, and detection of a repeated block.

// File: rtl/ehm_pkg.sv
package ehm_pkg;
  typedef logic [7:0] err_code_t;
  localparam err_code_t ERR_NONE = 8'h00;
  localparam err_code_t ERR_RUN  = 8'h2C;
  localparam err_code_t ERR_PROP = 8'h2D;
  localparam err_code_t ERR_DUP  = 8'h1E;

  typedef enum logic [1:0] {
    PK_FILL  = 2'd0,
    PK_CHECK = 2'd1,
    PK_HOLD  = 2'd2
  } pack_state_t;
endpackage

// File: rtl/ehm_run_test.sv
module ehm_run_test #(
  parameter int SMP_W  = 8,
  parameter int CUTOFF = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic [SMP_W-1:0] din,
  output logic             fail
);
  localparam int RW = $clog2(CUTOFF + 2);

  logic [SMP_W-1:0] last_q;
  logic [RW-1:0]    run_q;
  logic             have_q;
  logic [RW-1:0]    run_nx;

  // length of the run including the current sample
  always_comb begin
    if (have_q && (din == last_q)) run_nx = run_q + 1'b1;
    else                           run_nx = RW'(1);
  end

  assign fail = vld && (run_nx >= RW'(CUTOFF));

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '0;
      run_q  <= '0;
      have_q <= 1'b0;
    end else if (vld) begin
      last_q <= din;
      have_q <= 1'b1;
      run_q  <= (run_nx > RW'(CUTOFF)) ? RW'(CUTOFF) : run_nx;
    end
  end
endmodule

// File: rtl/ehm_prop_test.sv
module ehm_prop_test #(
  parameter int SMP_W  = 8,
  parameter int WINDOW = 512,
  parameter int CUTOFF = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic [SMP_W-1:0] din,
  output logic             fail
);
  localparam int PW = $clog2(WINDOW);
  localparam int CW = $clog2(CUTOFF + 2);

  logic [PW-1:0]    pos_q;
  logic [SMP_W-1:0] ref_q;
  logic [CW-1:0]    hits_q;
  logic [CW-1:0]    hits_nx;
  logic             match;

  assign match   = (pos_q != '0) && (din == ref_q);
  assign hits_nx = hits_q + 1'b1;
  assign fail    = vld && match && (hits_nx >= CW'(CUTOFF));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      ref_q  <= '0;
      hits_q <= '0;
    end else if (vld) begin
      pos_q <= (pos_q == PW'(WINDOW - 1)) ? '0 : pos_q + 1'b1;
      if (pos_q == '0) begin
        ref_q  <= din;
        hits_q <= CW'(1);
      end else if (match && (hits_q < CW'(CUTOFF))) begin
        hits_q <= hits_nx;
      end
    end
  end
endmodule

// File: rtl/ehm_seed_pack.sv
module ehm_seed_pack
  import ehm_pkg::*;
#(
  parameter int SMP_W  = 8,
  parameter int SEED_W = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [SMP_W-1:0]  in_byte,
  input  logic              take,
  output logic              accept,
  output logic              hold,
  output logic              dup,
  output logic [SEED_W-1:0] seed
);
  localparam int NSLOT = SEED_W / SMP_W;
  localparam int IW    = $clog2(NSLOT);

  pack_state_t      st_q;
  logic [IW-1:0]    idx_q;
  logic             prev_vld_q;
  logic [SMP_W-1:0] slot_q [NSLOT];
  logic [SMP_W-1:0] prev_q [NSLOT];
  logic [NSLOT-1:0] same;

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_slot
      assign seed[g*SMP_W +: SMP_W] = slot_q[g];
      assign same[g] = (slot_q[g] == prev_q[g]);
    end
  endgenerate

  assign accept = (st_q == PK_FILL);
  assign hold   = (st_q == PK_HOLD);
  assign dup    = (st_q == PK_CHECK) && prev_vld_q && (&same);

  // storage written without reset so it maps onto plain memory bits
  always_ff @(posedge clk) begin
    if ((st_q == PK_FILL) && in_vld) slot_q[idx_q] <= in_byte;
    if ((st_q == PK_CHECK) && !dup)  prev_q <= slot_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= PK_FILL;
      idx_q      <= '0;
      prev_vld_q <= 1'b0;
    end else begin
      case (st_q)
        PK_FILL: if (in_vld) begin
          if (idx_q == IW'(NSLOT - 1)) begin
            idx_q <= '0;
            st_q  <= PK_CHECK;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        PK_CHECK: begin
          if (dup) begin
            st_q <= PK_FILL;
          end else begin
            prev_vld_q <= 1'b1;
            st_q       <= PK_HOLD;
          end
        end
        PK_HOLD: if (take) st_q <= PK_FILL;
        default: st_q <= PK_FILL;
      endcase
    end
  end
endmodule

// File: rtl/entropy_health_monitor.sv
module entropy_health_monitor
  import ehm_pkg::*;
#(
  parameter int SMP_W     = 8,
  parameter int SEED_W    = 512,
  parameter int H_X100    = 631,
  parameter int APT_WIN   = 512,
  parameter int APT_CUT   = 13,
  parameter int STARTUP_N = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              seed_req,
  output logic              seed_ready,
  output logic [SEED_W-1:0] seed_data,
  output logic              fail_flag,
  output logic [7:0]        err_code
);
  // run cutoff = 1 + ceil(20 / H), H given in hundredths of a bit
  localparam int RCT_CUT = 1 + (2000 + H_X100 - 1) / H_X100;
  localparam int SW      = $clog2(STARTUP_N);

  logic          err_q;
  err_code_t     code_q;
  logic          started_q;
  logic [SW-1:0] su_cnt_q;
  logic          live;
  logic          run_fail, prop_fail;
  logic          pk_accept, pk_hold, pk_dup, pk_vld, take;

  assign live   = smp_valid && !err_q;
  assign pk_vld = live && started_q && pk_accept;
  assign take   = seed_req && seed_ready;

  ehm_run_test #(.SMP_W(SMP_W), .CUTOFF(RCT_CUT)) u_run (
    .clk(clk), .rst(rst), .vld(live), .din(smp_data), .fail(run_fail)
  );

  ehm_prop_test #(.SMP_W(SMP_W), .WINDOW(APT_WIN), .CUTOFF(APT_CUT)) u_prop (
    .clk(clk), .rst(rst), .vld(live), .din(smp_data), .fail(prop_fail)
  );

  ehm_seed_pack #(.SMP_W(SMP_W), .SEED_W(SEED_W)) u_pack (
    .clk(clk), .rst(rst), .in_vld(pk_vld), .in_byte(smp_data), .take(take),
    .accept(pk_accept), .hold(pk_hold), .dup(pk_dup), .seed(seed_data)
  );

  // startup phase: count clean samples before packing is enabled
  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      su_cnt_q  <= '0;
    end else if (live && !started_q) begin
      if (su_cnt_q == SW'(STARTUP_N - 1)) started_q <= 1'b1;
      else                                su_cnt_q  <= su_cnt_q + 1'b1;
    end
  end

  // first failure wins; run test has priority over proportion test
  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= 1'b0;
      code_q <= ERR_NONE;
    end else if (!err_q) begin
      if (run_fail) begin
        err_q  <= 1'b1;
        code_q <= ERR_RUN;
      end else if (prop_fail) begin
        err_q  <= 1'b1;
        code_q <= ERR_PROP;
      end else if (pk_dup) begin
        err_q  <= 1'b1;
        code_q <= ERR_DUP;
      end
    end
  end

  assign seed_ready = pk_hold && !err_q;
  assign fail_flag  = err_q;
  assign err_code   = code_q;
endmodule

// File: rtl/ehm_checker.sv
module ehm_checker #(
  parameter int SEED_W    = 512,
  parameter int STARTUP_N = 1024
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_valid,
  input logic              seed_req,
  input logic              seed_ready,
  input logic [SEED_W-1:0] seed_data,
  input logic              fail_flag,
  input logic [7:0]        err_code
);
  localparam int CW = $clog2(STARTUP_N + 1);

  logic [CW-1:0] seen_q;
  logic          was_rst_q;

  always_ff @(posedge clk) begin
    was_rst_q <= rst;
    if (rst)                                         seen_q <= '0;
    else if (smp_valid && (seen_q < CW'(STARTUP_N))) seen_q <= seen_q + 1'b1;
  end

  // R1: outputs idle in the cycle after reset is sampled
  always_ff @(posedge clk) begin
    if (was_rst_q) begin
      assert_reset_idle_R1: assert (!seed_ready && !fail_flag && err_code == 8'h00)
        else $error("reset state violated");
    end
  end

  assert_startup_gate_R2: assert property (@(posedge clk) disable iff (rst)
    seed_ready |-> (seen_q >= CW'(STARTUP_N)));

  assert_seed_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (seed_ready && !seed_req) |=> ($stable(seed_data) && (seed_ready || fail_flag)));

  assert_take_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (seed_ready && seed_req) |=> !seed_ready);

  assert_sticky_error_R8: assert property (@(posedge clk) disable iff (rst)
    fail_flag |=> (fail_flag && $stable(err_code)));

  assert_no_seed_in_error_R8: assert property (@(posedge clk) disable iff (rst)
    fail_flag |-> !seed_ready);

  // R5 R6 R7: only the defined codes appear, and only with the flag
  assert_code_legal_R7: assert property (@(posedge clk) disable iff (rst)
    fail_flag ? (err_code == 8'h2C || err_code == 8'h2D || err_code == 8'h1E)
              : (err_code == 8'h00));
endmodule

bind entropy_health_monitor ehm_checker #(.SEED_W(SEED_W), .STARTUP_N(STARTUP_N)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .seed_req(seed_req),
  .seed_ready(seed_ready), .seed_data(seed_data), .fail_flag(fail_flag),
  .err_code(err_code)
);

// File: tb/sim_entropy_health_monitor.sv
module sim_entropy_health_monitor;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         smp_valid = 1'b0;
  logic [7:0]   smp_data = 8'h00;
  logic         seed_req = 1'b0;
  logic         seed_ready;
  logic [511:0] seed_data;
  logic         fail_flag;
  logic [7:0]   err_code;

  always #10 clk = ~clk;

  entropy_health_monitor u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .seed_req(seed_req), .seed_ready(seed_ready), .seed_data(seed_data),
    .fail_flag(fail_flag), .err_code(err_code)
  );

  int checks = 0;
  int errors = 0;
  int gi = 0;
  int taken = 0;
  bit mon_hold = 1'b0;
  logic [511:0] sb_q[$];
  logic [511:0] acc;
  logic [511:0] saved;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = b;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    smp_valid = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!seed_ready, "R1", "seed_ready in reset", 512'(seed_ready), 0);
    chk(!fail_flag, "R1", "fail_flag in reset", 512'(fail_flag), 0);
    chk(err_code == 8'h00, "R1", "err_code in reset", 512'(err_code), 0);
    rst = 1'b0;
  endtask

  task automatic send_gen(input int n);
    for (int k = 0; k < n; k++) begin
      send(gen(gi));
      gi++;
    end
  endtask

  // driver: send one block and push its expected seed to the scoreboard
  task automatic push_blk();
    for (int k = 0; k < 64; k++) begin
      acc[8*k +: 8] = gen(gi);
      send(gen(gi));
      gi++;
    end
    sb_q.push_back(acc);
    idle(1);
  endtask

  task automatic wait_take(input int n);
    while (taken < n) @(negedge clk);
  endtask

  task automatic wait_ready();
    while (!seed_ready) @(negedge clk);
  endtask

  // monitor: pop and compare every offered seed, then take it
  initial begin
    forever begin
      @(negedge clk);
      if (seed_ready && !mon_hold) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R7", "seed offered with none expected", seed_data, 0);
        end else begin
          logic [511:0] e;
          e = sb_q.pop_front();
          chk(seed_data == e, "R3", "seed contents", seed_data, e);
        end
        seed_req = 1'b1;
        @(negedge clk);
        seed_req = 1'b0;
        chk(!seed_ready, "R4", "ready after take", 512'(seed_ready), 0);
        taken++;
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    finish_run();
  end

  initial begin
    // main flow: startup, packing, handshake
    do_reset();
    send_gen(1024);
    idle(4);
    chk(!seed_ready, "R2", "no seed from startup samples", 512'(seed_ready), 0);
    chk(!fail_flag, "R2", "clean startup", 512'(fail_flag), 0);
    push_blk();
    wait_take(1);
    push_blk();
    wait_take(2);

    // R4: hold a seed, feed samples meanwhile, they must be dropped
    mon_hold = 1'b1;
    push_blk();
    wait_ready();
    saved = seed_data;
    send_gen(5);
    idle(5);
    chk(seed_ready, "R4", "ready held while not taken", 512'(seed_ready), 1);
    chk(seed_data == saved, "R4", "seed stable while held", seed_data, saved);
    mon_hold = 1'b0;
    wait_take(3);
    push_blk();
    wait_take(4);
    chk(!fail_flag, "R3", "no failure on clean stream", 512'(fail_flag), 0);

    // R8: failure while a seed waits withdraws it
    mon_hold = 1'b1;
    push_blk();
    wait_ready();
    for (int k = 0; k < 5; k++) send(8'h5A);
    idle(1);
    chk(fail_flag, "R8", "flag on run failure", 512'(fail_flag), 1);
    chk(err_code == 8'h2C, "R8", "code on run failure", 512'(err_code), 512'h2C);
    chk(!seed_ready, "R8", "pending seed withdrawn", 512'(seed_ready), 0);
    send_gen(10);
    @(negedge clk);
    seed_req = 1'b1;
    @(negedge clk);
    seed_req = 1'b0;
    idle(4);
    chk(fail_flag && err_code == 8'h2C, "R8", "error sticky", 512'(err_code), 512'h2C);
    chk(!seed_ready, "R8", "no seed after request in error", 512'(seed_ready), 0);
    sb_q.delete();
    mon_hold = 1'b0;

    // R5: four repeats pass, fifth fails, idle gaps do not break the run
    do_reset();
    send_gen(10);
    send(8'h11);
    for (int k = 0; k < 4; k++) begin
      send(8'h77);
      idle(2);
    end
    chk(!fail_flag, "R5", "four repeats pass", 512'(fail_flag), 0);
    send(8'h77);
    idle(1);
    chk(fail_flag, "R5", "fifth repeat fails", 512'(fail_flag), 1);
    chk(err_code == 8'h2C, "R5", "run code", 512'(err_code), 512'h2C);

    // R6: 12 matches of the window's first sample pass, 13 fail
    do_reset();
    for (int k = 0; k < 24; k++) send((k % 2 == 0) ? 8'hA5 : 8'(k));
    idle(2);
    chk(!fail_flag, "R6", "twelve matches pass", 512'(fail_flag), 0);
    send(8'hA5);
    idle(1);
    chk(fail_flag, "R6", "thirteen matches fail", 512'(fail_flag), 1);
    chk(err_code == 8'h2D, "R6", "proportion code", 512'(err_code), 512'h2D);

    // R9: one sample trips both tests, run code wins
    do_reset();
    for (int k = 0; k < 16; k++) send((k % 2 == 0) ? 8'h3C : 8'(k + 8'h40));
    for (int k = 0; k < 4; k++) send(8'h3C);
    idle(2);
    chk(!fail_flag, "R9", "twelve matches with run four pass", 512'(fail_flag), 0);
    send(8'h3C);
    idle(1);
    chk(err_code == 8'h2C, "R9", "priority of run code", 512'(err_code), 512'h2C);

    // R7: a block repeating the previous one is caught and never offered
    do_reset();
    send_gen(1024);
    for (int k = 0; k < 64; k++) begin
      acc[8*k +: 8] = 8'(k * 4 + 1);
      send(8'(k * 4 + 1));
    end
    sb_q.push_back(acc);
    idle(1);
    wait_take(taken + 1);
    for (int k = 0; k < 64; k++) send(8'(k * 4 + 1));
    idle(4);
    chk(fail_flag, "R7", "repeated block flagged", 512'(fail_flag), 1);
    chk(err_code == 8'h1E, "R7", "repeated block code", 512'(err_code), 512'h1E);
    repeat (5) @(negedge clk);
    chk(!seed_ready, "R7", "repeated block not offered", 512'(seed_ready), 0);

    do_reset();
    chk(!fail_flag && err_code == 8'h00, "R8", "reset clears error", 512'(err_code), 0);
    finish_run();
  end
endmodule